// File: doc/BRIEF.md
# Clock Multiplier Bring-Up Sequencer

This block is the digital front end of an analog clock multiplier. It drives the loop's pre-divider setting, its multiplication factor, its reset pin and the select that decides whether the chip runs from the reference clock (bypass) or from the multiplied clock. A glitch-free clock switch inside the block makes that select safe. Software sets the pre-divider, the multiplier code and the enable controls through a small write port. A change request then starts a fixed sequence. The sequence moves the chip to bypass and confirms the move, asserts the loop reset, loads the new settings, holds reset for a counted time, releases it, waits a counted lock time, and only then lets the output move to the multiplied clock.

The loop itself lives outside the block. Its settings only reach the loop while the loop is held in reset. The first bring-up after power-on finds the loop already in reset, so it shortens the hold to a single cycle. A boot strap can force the x15 factor and start that first bring-up without any software involvement.

Top module: `clkmul_seq`

## Requirements
- R1: After reset the block holds `pll_rst` high, `pll_en`, `locked`, `busy`, `cfg_err` and `clk_is_mult` low, `pll_mult` at 15 and `pll_prediv` at 0.
- R2: A write to address 1 stores `wr_data[PDIV_W-1:0]` as the pre-divider. A write to address 2 stores a multiplier code, where codes 0,1,2,3,4 select factors 15,20,25,30,32. Stored settings appear on `pll_prediv` and `pll_mult` only during the next sequence.
- R3: A multiplier write whose whole data word exceeds 4 is ignored, and it sets `cfg_err`, which stays high until reset.
- R4: Within a sequence, `pll_rst` rises only once `clk_is_mult` is low. `pll_prediv` and `pll_mult` change only at a clock edge with `pll_rst` high both before and after that edge.
- R5: In every sequence except the first after reset, `pll_rst` stays high for exactly HOLD_CYC+1 reference cycles (one load cycle plus the hold).
- R6: In the first sequence after reset, `pll_rst` falls four cycles after the request edge, so the long hold is skipped.
- R7: `locked` is low from the start of a sequence and rises exactly LOCK_CYC reference cycles after `pll_rst` falls. `locked` is never high while `pll_rst` is high.
- R8: Address 0 holds the enable source in bit 0 (reset 1) and the run enable in bit 1 (reset 0). `pll_en` is high only when `locked` is high, the enable source is 0 and the run enable is 1. `clk_is_mult` follows `pll_en`.
- R9: `busy` rises one cycle after a request (a write to address 3 with bit 0 set). It stays high until the sequence has ended and `clk_is_mult` equals `pll_en`.
- R10: A request that arrives while a sequence runs is held, and it starts a second full sequence once the first ends.
- R11: With `boot_x15` high at reset release, the block forces code x15, clears the enable source, sets the run enable and runs a bring-up on its own. The bring-up ends on the multiplied clock.
- R12: The two clock legs of `clk_out` are never enabled together. `clk_out` follows the reference clock in bypass and the multiplied clock otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the controller and is the bypass clock |
| pll_clk | input | 1 | Multiplied clock from the analog loop |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_x15 | input | 1 | Boot strap; forces x15 bring-up at reset release |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 pre-divider, 2 multiplier code, 3 request |
| wr_data | input | DATA_W | Write data |
| pll_rst | output | 1 | Loop reset, active high |
| pll_en | output | 1 | Select request for the multiplied clock |
| pll_prediv | output | PDIV_W | Pre-divider value applied to the loop |
| pll_mult | output | 6 | Multiplication factor applied to the loop |
| clk_out | output | 1 | Glitch-free switched clock |
| clk_is_mult | output | 1 | The switch currently passes the multiplied clock |
| busy | output | 1 | A request is pending, a sequence runs, or a switch-over is in flight |
| locked | output | 1 | Lock wait finished since the last loop reset |
| cfg_err | output | 1 | Sticky flag for a rejected multiplier code |

## Verification
The bench builds the block with HOLD_CYC=4, LOCK_CYC=12 and PDIV_W=5. With these values a whole sequence takes a few dozen cycles. That is short enough to sweep all eight multiplier codes, each paired with its own pre-divider and one of three enable combinations, and to compare the reset-hold and lock-wait lengths for exact equality on every run. The short windows also let one bench cover both the software-started bring-up and the strap-forced bring-up after a second reset, as well as a request queued during a running sequence.

// File: rtl/clkmul_pkg.sv
`timescale 1ns/1ps
package clkmul_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BYP  = 3'd1,
    ST_LOAD = 3'd2,
    ST_HOLD = 3'd3,
    ST_LOCK = 3'd4
  } seq_state_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_PDIV = 2'd1;
  localparam logic [1:0] ADR_MULT = 2'd2;
  localparam logic [1:0] ADR_GO   = 2'd3;

  localparam int          MCODE_W = 3;
  localparam int          MULT_W  = 6;
  localparam logic [2:0]  MC_X15  = 3'd0;
  localparam logic [2:0]  MC_LAST = 3'd4;

  // code to loop factor: 15, 20, 25, 30 in steps of five, then 32
  function automatic logic [MULT_W-1:0] mult_factor(input logic [MCODE_W-1:0] code);
    logic [MULT_W-1:0] f;
    if (code == MC_LAST) f = MULT_W'(32);
    else                 f = MULT_W'(15) + MULT_W'(5) * MULT_W'(code);
    return f;
  endfunction

endpackage

// File: rtl/clkmul_regs.sv
`timescale 1ns/1ps
module clkmul_regs
  import clkmul_pkg::*;
#(
  parameter int PDIV_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_x15,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                start,
  output logic                en_src,
  output logic                run_en,
  output logic [PDIV_W-1:0]   pdiv_sh,
  output logic [MCODE_W-1:0]  mcode_sh,
  output logic                pend,
  output logic                err
);

  logic               strap_q, strap_n;
  logic               en_src_q, en_src_n;
  logic               run_en_q, run_en_n;
  logic [PDIV_W-1:0]  pdiv_q, pdiv_n;
  logic [MCODE_W-1:0] mcode_q, mcode_n;
  logic               pend_q, pend_n;
  logic               err_q, err_n;
  logic               go;
  logic               code_bad;

  assign code_bad = wr_data > DATA_W'(MC_LAST);

  always_comb begin
    strap_n  = strap_q;
    en_src_n = en_src_q;
    run_en_n = run_en_q;
    pdiv_n   = pdiv_q;
    mcode_n  = mcode_q;
    err_n    = err_q;
    go       = 1'b0;
    if (!strap_q) begin
      strap_n = 1'b1;
      if (boot_x15) begin
        mcode_n  = MC_X15;
        en_src_n = 1'b0;
        run_en_n = 1'b1;
        go       = 1'b1;
      end
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          en_src_n = wr_data[0];
          run_en_n = wr_data[1];
        end
        ADR_PDIV: pdiv_n = wr_data[PDIV_W-1:0];
        ADR_MULT: begin
          if (code_bad) err_n   = 1'b1;
          else          mcode_n = wr_data[MCODE_W-1:0];
        end
        default:  go = wr_data[0];
      endcase
    end
    pend_n = go | (pend_q & ~start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= 1'b0;
      en_src_q <= 1'b1;
      run_en_q <= 1'b0;
      pdiv_q   <= '0;
      mcode_q  <= MC_X15;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      strap_q  <= strap_n;
      en_src_q <= en_src_n;
      run_en_q <= run_en_n;
      pdiv_q   <= pdiv_n;
      mcode_q  <= mcode_n;
      pend_q   <= pend_n;
      err_q    <= err_n;
    end
  end

  assign en_src   = en_src_q;
  assign run_en   = run_en_q;
  assign pdiv_sh  = pdiv_q;
  assign mcode_sh = mcode_q;
  assign pend     = pend_q;
  assign err      = err_q;

  // R3: a rejected code flags and leaves the stored code alone
  a_r3_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_q && wr_en && wr_addr == ADR_MULT && code_bad) |=> (err_q && $stable(mcode_q)));

  // R3: error flag never clears without reset
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R10: a pending request survives until the sequencer takes it
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !start) |=> pend_q);

endmodule

// File: rtl/clkmul_fsm.sv
`timescale 1ns/1ps
module clkmul_fsm
  import clkmul_pkg::*;
#(
  parameter int PDIV_W   = 5,
  parameter int HOLD_CYC = 256,
  parameter int LOCK_CYC = 3000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pend,
  input  logic [PDIV_W-1:0]   pdiv_sh,
  input  logic [MCODE_W-1:0]  mcode_sh,
  input  logic                mul_active,
  output logic                start,
  output logic                pll_rst,
  output logic                locked,
  output logic [PDIV_W-1:0]   pdiv_out,
  output logic [MCODE_W-1:0]  mcode_out,
  output logic                seq_busy
);

  localparam int CNT_MAX = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);

  seq_state_t         state_q, state_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               rst_q, rst_n_nx;
  logic               locked_q, locked_n;
  logic               first_q, first_n;
  logic [PDIV_W-1:0]  pdiv_q, pdiv_n;
  logic [MCODE_W-1:0] mcode_q, mcode_n;
  logic [CNT_W-1:0]   hold_end;

  assign hold_end = first_q ? '0 : HOLD_LAST;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    rst_n_nx = rst_q;
    locked_n = locked_q;
    first_n  = first_q;
    pdiv_n   = pdiv_q;
    mcode_n  = mcode_q;
    start    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend) begin
          start    = 1'b1;
          locked_n = 1'b0;
          state_n  = ST_BYP;
        end
      end
      ST_BYP: begin
        if (!mul_active) begin
          rst_n_nx = 1'b1;
          state_n  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        pdiv_n  = pdiv_sh;
        mcode_n = mcode_sh;
        cnt_n   = '0;
        state_n = ST_HOLD;
      end
      ST_HOLD: begin
        if (cnt_q == hold_end) begin
          rst_n_nx = 1'b0;
          first_n  = 1'b0;
          cnt_n    = '0;
          state_n  = ST_LOCK;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_LOCK: begin
        if (cnt_q == LOCK_LAST) begin
          locked_n = 1'b1;
          state_n  = ST_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rst_q    <= 1'b1;
      locked_q <= 1'b0;
      first_q  <= 1'b1;
      pdiv_q   <= '0;
      mcode_q  <= MC_X15;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      rst_q    <= rst_n_nx;
      locked_q <= locked_n;
      first_q  <= first_n;
      pdiv_q   <= pdiv_n;
      mcode_q  <= mcode_n;
    end
  end

  assign pll_rst   = rst_q;
  assign locked    = locked_q;
  assign pdiv_out  = pdiv_q;
  assign mcode_out = mcode_q;
  assign seq_busy  = (state_q != ST_IDLE);

  // R4: loop settings move only inside a reset window
  a_r4_cfg_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pdiv_q, mcode_q}) |-> (rst_q && $past(rst_q)));

  // R4: reset is applied only once the switch reports bypass
  a_r4_bypass_before_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> !mul_active);

  // R7: lock is never reported with the loop in reset
  a_r7_locked_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !rst_q);

  // R7: a fresh lock only ever follows the lock-wait state
  a_r7_lock_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(state_q == ST_LOCK));

endmodule

// File: rtl/clkmul_gmux.sv
`timescale 1ns/1ps
module clkmul_gmux (
  input  logic ref_clk,
  input  logic pll_clk,
  input  logic rst_ref_n,
  input  logic rst_n,
  input  logic sel_mult,
  output logic clk_out,
  output logic mul_active
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] r_sync_q;
  logic              en_ref_q, en_ref_n;
  logic [SYNC_N-1:0] m_sel_q;
  logic [SYNC_N-1:0] m_ref_q;
  logic              en_mul_q, en_mul_n;

  // reference leg: opens only after the multiplied leg is seen closed
  assign en_ref_n = ~sel_mult & ~r_sync_q[SYNC_N-1];

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) r_sync_q <= '0;
    else            r_sync_q <= {r_sync_q[SYNC_N-2:0], en_mul_q};
  end

  always_ff @(negedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) en_ref_q <= 1'b1;
    else            en_ref_q <= en_ref_n;
  end

  // multiplied leg: opens only after the reference leg is seen closed
  assign en_mul_n = m_sel_q[SYNC_N-1] & ~m_ref_q[SYNC_N-1];

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel_q <= '0;
      m_ref_q <= '1;
    end else begin
      m_sel_q <= {m_sel_q[SYNC_N-2:0], sel_mult};
      m_ref_q <= {m_ref_q[SYNC_N-2:0], en_ref_q};
    end
  end

  always_ff @(negedge pll_clk or negedge rst_n) begin
    if (!rst_n) en_mul_q <= 1'b0;
    else        en_mul_q <= en_mul_n;
  end

  assign clk_out    = (ref_clk & en_ref_q) | (pll_clk & en_mul_q);
  assign mul_active = r_sync_q[SYNC_N-1];

  // R12: never both legs open
  a_r12_one_leg: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    $onehot0({en_ref_q, en_mul_q}));

  // R12: status of the multiplied leg implies the reference leg is shut
  a_r12_status_consistent: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    mul_active |-> !en_ref_q);

endmodule

// File: rtl/clkmul_seq.sv
`timescale 1ns/1ps
module clkmul_seq
  import clkmul_pkg::*;
#(
  parameter int PDIV_W   = 5,
  parameter int DATA_W   = 8,
  parameter int HOLD_CYC = 256,
  parameter int LOCK_CYC = 3000
) (
  input  logic               ref_clk,
  input  logic               pll_clk,
  input  logic               rst_n,
  input  logic               boot_x15,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               pll_rst,
  output logic               pll_en,
  output logic [PDIV_W-1:0]  pll_prediv,
  output logic [MULT_W-1:0]  pll_mult,
  output logic               clk_out,
  output logic               clk_is_mult,
  output logic               busy,
  output logic               locked,
  output logic               cfg_err
);

  logic [1:0]         rsync_q;
  logic               rst_ref_n;
  logic               en_src, run_en, pend, start, seq_busy, mul_active;
  logic [PDIV_W-1:0]  pdiv_sh, pdiv_out;
  logic [MCODE_W-1:0] mcode_sh, mcode_out;

  // reset asserts at once, releases on the reference clock
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ref_n = rsync_q[1];

  clkmul_regs #(.PDIV_W(PDIV_W), .DATA_W(DATA_W)) u_regs (
    .clk      (ref_clk),
    .rst_n    (rst_ref_n),
    .boot_x15 (boot_x15),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .start    (start),
    .en_src   (en_src),
    .run_en   (run_en),
    .pdiv_sh  (pdiv_sh),
    .mcode_sh (mcode_sh),
    .pend     (pend),
    .err      (cfg_err)
  );

  clkmul_fsm #(.PDIV_W(PDIV_W), .HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk        (ref_clk),
    .rst_n      (rst_ref_n),
    .pend       (pend),
    .pdiv_sh    (pdiv_sh),
    .mcode_sh   (mcode_sh),
    .mul_active (mul_active),
    .start      (start),
    .pll_rst    (pll_rst),
    .locked     (locked),
    .pdiv_out   (pdiv_out),
    .mcode_out  (mcode_out),
    .seq_busy   (seq_busy)
  );

  assign pll_en = locked & ~en_src & run_en;

  clkmul_gmux u_gmux (
    .ref_clk    (ref_clk),
    .pll_clk    (pll_clk),
    .rst_ref_n  (rst_ref_n),
    .rst_n      (rst_n),
    .sel_mult   (pll_en),
    .clk_out    (clk_out),
    .mul_active (mul_active)
  );

  assign clk_is_mult = mul_active;
  assign pll_prediv  = pdiv_out;
  assign pll_mult    = mult_factor(mcode_out);
  assign busy        = pend | seq_busy | (pll_en != mul_active);

  // R8: multiplied clock requested only after lock
  a_r8_en_needs_lock: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    pll_en |-> locked);

  // R9: busy covers an unfinished switch-over
  a_r9_busy_until_switch: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (pll_en && !clk_is_mult) |-> busy);

  // R4: loop in reset implies the output runs from the reference
  a_r4_rst_on_bypass: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    pll_rst |-> !clk_is_mult);

endmodule

// File: tb/clkmul_seq_bench.sv
`timescale 1ns/1ps
module clkmul_seq_bench;

  localparam int PDIV_W = 5;
  localparam int DATA_W = 8;
  localparam int HOLD   = 4;
  localparam int LOCK   = 12;
  localparam logic [1:0] A_CTRL = 2'd0, A_PDIV = 2'd1, A_MULT = 2'd2, A_GO = 2'd3;

  logic              ref_clk = 1'b0;
  logic              pll_clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              boot_x15 = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              pll_rst, pll_en, clk_out, clk_is_mult, busy, locked, cfg_err;
  logic [PDIV_W-1:0] pll_prediv;
  logic [5:0]        pll_mult;

  int nvec = 0;
  int nerr = 0;
  int edges = 0;

  clkmul_seq #(.PDIV_W(PDIV_W), .DATA_W(DATA_W), .HOLD_CYC(HOLD), .LOCK_CYC(LOCK)) u_clkmul_seq (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n), .boot_x15(boot_x15),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_rst(pll_rst), .pll_en(pll_en), .pll_prediv(pll_prediv), .pll_mult(pll_mult),
    .clk_out(clk_out), .clk_is_mult(clk_is_mult), .busy(busy), .locked(locked),
    .cfg_err(cfg_err)
  );

  always #4 ref_clk = ~ref_clk;

  // loop model: runs only while out of reset
  always begin
    #1.5;
    if (pll_rst !== 1'b0) pll_clk = 1'b0;
    else                  pll_clk = ~pll_clk;
  end

  always @(posedge clk_out) edges++;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = DATA_W'(d);
    @(negedge ref_clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 100 && busy; i++) @(negedge ref_clk);
  endtask

  task automatic run_seq(input bit first, input int exp_f, input int exp_pd, input bit exp_en);
    int rh, lk, bad_ord, bad_cfg, t;
    bit seen;
    logic [5:0] pm;
    rh = 0; lk = 0; bad_ord = 0; bad_cfg = 0; t = 0;
    seen = first;
    pm = pll_mult;
    wr(A_GO, 1);
    chk("R9 busy after request", int'(busy), 1);
    while (busy && t < 400) begin
      if (pll_rst && busy) rh++;
      if (pll_rst) seen = 1'b1;
      if (seen && !pll_rst && !locked && busy) lk++;
      if (pll_rst && clk_is_mult) bad_ord++;
      if (pll_mult != pm && !pll_rst) bad_cfg++;
      pm = pll_mult;
      t++;
      @(negedge ref_clk);
    end
    chk("R5 R6 reset hold length", rh, first ? 4 : HOLD + 1);
    chk("R7 lock wait length", lk, LOCK);
    chk("R4 reset only on bypass", bad_ord, 0);
    chk("R4 settings change in reset", bad_cfg, 0);
    chk("R2 applied factor", int'(pll_mult), exp_f);
    chk("R2 applied prediv", int'(pll_prediv), exp_pd);
    chk("R7 locked at end", int'(locked), 1);
    chk("R8 enable after seq", int'(pll_en), int'(exp_en));
    chk("R9 switch done when idle", int'(clk_is_mult), int'(pll_en));
  endtask

  task automatic clk_count(input bit on_mult);
    int v;
    edges = 0;
    repeat (20) @(negedge ref_clk);
    v = edges;
    if (on_mult) chk("R12 fast clock passed", int'(v > 40), 1);
    else         chk("R12 reference passed", int'(v >= 19 && v <= 21), 1);
  endtask

  initial begin : wd
    repeat (150000) @(posedge ref_clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int expf, rises, t;
    logic prev;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge ref_clk);

    // R1 reset state
    chk("R1 pll_rst", int'(pll_rst), 1);
    chk("R1 pll_en", int'(pll_en), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    chk("R1 clk_is_mult", int'(clk_is_mult), 0);
    chk("R1 factor", int'(pll_mult), 15);
    chk("R1 prediv", int'(pll_prediv), 0);
    clk_count(1'b0);

    // R2 settings wait for a sequence; R6 short first hold
    wr(A_CTRL, 2);
    wr(A_PDIV, 3);
    wr(A_MULT, 1);
    repeat (3) @(negedge ref_clk);
    chk("R2 factor deferred", int'(pll_mult), 15);
    chk("R2 prediv deferred", int'(pll_prediv), 0);
    run_seq(1'b1, 20, 3, 1'b1);
    clk_count(1'b1);

    // sweep every code with three enable combinations
    expf = 20;
    for (int c = 0; c < 8; c++) begin
      int ctrl, pd;
      bit en;
      ctrl = (c % 3 == 0) ? 2 : ((c % 3 == 1) ? 3 : 0);
      en   = (c % 3 == 0);
      pd   = c * 4 + 1;
      wr(A_CTRL, ctrl);
      chk("R8 enable follows control", int'(pll_en), int'(en));
      settle();
      chk("R8 switch follows control", int'(clk_is_mult), int'(en));
      wr(A_PDIV, pd);
      wr(A_MULT, c);
      if (c <= 4) expf = (c == 4) ? 32 : 15 + 5 * c;
      chk("R3 error flag", int'(cfg_err), int'(c >= 5));
      run_seq(1'b0, expf, pd, en);
      clk_count(en);
    end

    // R10 request during a sequence runs a second one
    wr(A_CTRL, 2);
    settle();
    rises = 0; t = 0;
    prev = pll_rst;
    wr(A_GO, 1);
    repeat (3) @(negedge ref_clk);
    wr(A_GO, 1);
    while (busy && t < 600) begin
      if (pll_rst && !prev) rises++;
      prev = pll_rst;
      t++;
      @(negedge ref_clk);
    end
    chk("R10 two sequences", rises, 2);
    chk("R10 ends locked", int'(locked), 1);

    // R11 strap-forced bring-up
    boot_x15 = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    t = 0;
    while (!busy && t < 20) begin t++; @(negedge ref_clk); end
    chk("R11 bring-up started", int'(busy), 1);
    t = 0;
    while (busy && t < 300) begin t++; @(negedge ref_clk); end
    chk("R11 factor", int'(pll_mult), 15);
    chk("R11 locked", int'(locked), 1);
    chk("R11 enable", int'(pll_en), 1);
    chk("R11 on fast clock", int'(clk_is_mult), 1);
    chk("R11 no error", int'(cfg_err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule